// File: doc/BRIEF.md
# Interrupt Priority and CPU-Target Register Bank

This block holds the per-interrupt configuration that an interrupt distributor needs for its shared interrupts. Each shared interrupt owns one priority byte and one CPU-target byte. Both are reached over a small 32-bit register bus that has a write-enable and four byte strobes. Next to these two arrays sit three read-only words: a type word that describes the configuration, an implementer identification word, and a peripheral identification word.

The block does not signal interrupts and it does not arbitrate between them. It stores fields and masks them in hardware. A priority byte keeps only its top `PRIO_BITS` bits. A target byte keeps only the bits for CPUs that exist. Any word outside the implemented shared range reads as zero, and writes to it are dropped. Software can find out how many priority bits are implemented by writing all ones to a priority byte and reading it back.

The bus carries a word address, so byte offset 0x420 is presented as 0x108. The priority array starts at byte offset 0x400 and the target array at 0x800, with one byte per interrupt ID. Shared IDs start at 32. The type word is at byte 0x004, the implementer ID at 0x008 and the peripheral ID at 0xFE8. A read returns its data on `rdata_o` one clock after the request.

Top module: `irq_prio_target_regs`

## Requirements
- R1: After reset, every stored priority and target byte reads as zero, and `rdata_o` is zero.
- R2: A priority byte reads back with its low `8-PRIO_BITS` bits at zero, whatever was written (mask 0xF8 with the default of 5 bits).
- R3: All four priority bytes of one word apply the same implemented-bit mask.
- R4: A write with only some bits of `be_i` set changes only those byte lanes; `be_i[k]` selects bits 8k+7:8k.
- R5: In a target byte, bit c reads as zero and ignores writes when c >= `NUM_CPUS` (mask 0x0F with the default of 4 CPUs).
- R6: Priority or target words for IDs below 32, or at or above `NUM_IRQS`, read as zero, and writes to them have no effect.
- R7: The type word reads bits 7:5 as `NUM_CPUS-1`, bits 4:0 as `NUM_IRQS/32-1`, and all other bits as zero (0x61 with the defaults).
- R8: The type, implementer ID and peripheral ID words are read-only: writes leave their read values unchanged.
- R9: A read request updates `rdata_o` at the next clock edge. `rdata_o` holds its value in every cycle that has no read request.
- R10: The priority and target bytes of the same interrupt are stored separately, so a write to one leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| waddr_i | input | 10 | Word address (byte offset bits 11:2) |
| be_i | input | 4 | Byte-lane write strobes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |

## Verification
The bound checker runs on every cycle. It checks that a priority read never shows unimplemented low bits, that a target read never shows bits for absent CPUs, and that out-of-range reads return zero. It also checks the type and identification values and that `rdata_o` holds between reads. Several behaviours need a sequence of accesses and so can only be shown by the bench's scenarios: which byte lanes a strobed write changes, that dropped writes leave no trace, that the priority and target arrays stay independent, and that reset clears the stored fields.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int unsigned WADDR_W      = 10;
  localparam int unsigned FIRST_SHARED = 32;
  localparam logic [WADDR_W-1:0] TYPE_WADDR   = 10'h001;
  localparam logic [WADDR_W-1:0] IMPL_WADDR   = 10'h002;
  localparam logic [WADDR_W-1:0] PERIPH_WADDR = 10'h3FA;
  localparam logic [1:0] REGION_PRIO = 2'b01;
  localparam logic [1:0] REGION_TGT  = 2'b10;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_TYPE, SEL_IMPL, SEL_PERIPH, SEL_PRIO, SEL_TGT
  } sel_e;

  function automatic logic [7:0] prio_mask(int unsigned bits);
    return 8'(8'hFF << (8 - bits));
  endfunction

  function automatic logic [7:0] cpu_mask(int unsigned cpus);
    return 8'((9'h1 << cpus) - 9'h1);
  endfunction
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_regs_pkg::*;
#(
  parameter int unsigned NUM_IRQS = 64,
  localparam int unsigned SPI_WORDS = (NUM_IRQS - FIRST_SHARED) / 4,
  localparam int unsigned IDX_W = $clog2(SPI_WORDS)
) (
  input  logic [WADDR_W-1:0] waddr_i,
  output sel_e               sel_o,
  output logic [IDX_W-1:0]   idx_o
);
  localparam int unsigned WORDS_TOTAL = NUM_IRQS / 4;
  localparam logic [7:0]  FIRST_WORD  = 8'(FIRST_SHARED / 4);

  logic [1:0] region;
  logic [7:0] word;
  logic       in_range;

  assign region   = waddr_i[9:8];
  assign word     = waddr_i[7:0];
  assign in_range = (word >= FIRST_WORD) && (32'(word) < WORDS_TOTAL);
  assign idx_o    = IDX_W'(word - FIRST_WORD);

  always_comb begin
    sel_o = SEL_NONE;
    if (waddr_i == TYPE_WADDR)        sel_o = SEL_TYPE;
    else if (waddr_i == IMPL_WADDR)   sel_o = SEL_IMPL;
    else if (waddr_i == PERIPH_WADDR) sel_o = SEL_PERIPH;
    else if (in_range && region == REGION_PRIO) sel_o = SEL_PRIO;
    else if (in_range && region == REGION_TGT)  sel_o = SEL_TGT;
  end
endmodule

// File: rtl/irq_field_bank.sv
module irq_field_bank #(
  parameter int unsigned NUM_WORDS = 8,
  parameter logic [7:0]  LANE_MASK = 8'hFF,
  localparam int unsigned IDX_W = $clog2(NUM_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [3:0]       be_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o
);
  logic [31:0] words_q [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar l = 0; l < 4; l++) begin : g_lane
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          words_q[w][l*8 +: 8] <= 8'h00;
        else if (we_i && idx_i == IDX_W'(w) && be_i[l])
          words_q[w][l*8 +: 8] <= wdata_i[l*8 +: 8] & LANE_MASK;
      end
    end
  end

  assign rdata_o = words_q[idx_i];
endmodule

// File: rtl/irq_prio_target_regs.sv
module irq_prio_target_regs
  import irq_regs_pkg::*;
#(
  parameter int unsigned NUM_IRQS  = 64,
  parameter int unsigned NUM_CPUS  = 4,
  parameter int unsigned PRIO_BITS = 5,
  parameter logic [31:0] IMPL_ID   = 32'h0001_1A5E,
  parameter logic [31:0] PERIPH_ID = 32'h0000_002B
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [WADDR_W-1:0] waddr_i,
  input  logic [3:0]         be_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o
);
  localparam int unsigned SPI_WORDS = (NUM_IRQS - FIRST_SHARED) / 4;
  localparam int unsigned IDX_W     = $clog2(SPI_WORDS);
  localparam logic [7:0]  P_MASK    = prio_mask(PRIO_BITS);
  localparam logic [7:0]  T_MASK    = cpu_mask(NUM_CPUS);
  localparam logic [31:0] TYPE_VAL  = {24'h0, 3'(NUM_CPUS - 1), 5'(NUM_IRQS / 32 - 1)};

  sel_e             sel;
  logic [IDX_W-1:0] idx;
  logic [31:0]      prio_rd, tgt_rd, rd_mux, rdata_q;
  logic             prio_we, tgt_we;

  irq_reg_decode #(.NUM_IRQS(NUM_IRQS)) u_dec (
    .waddr_i(waddr_i), .sel_o(sel), .idx_o(idx)
  );

  assign prio_we = req_i && we_i && sel == SEL_PRIO;
  assign tgt_we  = req_i && we_i && sel == SEL_TGT;

  irq_field_bank #(.NUM_WORDS(SPI_WORDS), .LANE_MASK(P_MASK)) u_prio (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(prio_we), .idx_i(idx),
    .be_i(be_i), .wdata_i(wdata_i), .rdata_o(prio_rd)
  );

  irq_field_bank #(.NUM_WORDS(SPI_WORDS), .LANE_MASK(T_MASK)) u_tgt (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(tgt_we), .idx_i(idx),
    .be_i(be_i), .wdata_i(wdata_i), .rdata_o(tgt_rd)
  );

  always_comb begin
    unique case (sel)
      SEL_TYPE:   rd_mux = TYPE_VAL;
      SEL_IMPL:   rd_mux = IMPL_ID;
      SEL_PERIPH: rd_mux = PERIPH_ID;
      SEL_PRIO:   rd_mux = prio_rd;
      SEL_TGT:    rd_mux = tgt_rd;
      default:    rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rdata_q <= 32'h0;
    else if (req_i && !we_i)   rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_prio_target_regs_chk.sv
module irq_prio_target_regs_chk
  import irq_regs_pkg::*;
#(
  parameter int unsigned NUM_IRQS  = 64,
  parameter int unsigned NUM_CPUS  = 4,
  parameter int unsigned PRIO_BITS = 5,
  parameter logic [31:0] IMPL_ID   = 32'h0001_1A5E,
  parameter logic [31:0] PERIPH_ID = 32'h0000_002B
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [WADDR_W-1:0] waddr_i,
  input logic [31:0]        rdata_o
);
  localparam logic [31:0] P_WORD = {4{prio_mask(PRIO_BITS)}};
  localparam logic [31:0] T_WORD = {4{cpu_mask(NUM_CPUS)}};
  localparam logic [31:0] TYPE_EXP = 32'(((NUM_CPUS - 1) << 5) | (NUM_IRQS / 32 - 1));

  logic rd, field_region, outside;
  assign rd           = req_i && !we_i;
  assign field_region = waddr_i[9:8] == REGION_PRIO || waddr_i[9:8] == REGION_TGT;
  assign outside      = 32'(waddr_i[7:0]) < FIRST_SHARED / 4 || 32'(waddr_i[7:0]) >= NUM_IRQS / 4;

  a_r2_prio_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && waddr_i[9:8] == REGION_PRIO) |=> (rdata_o & ~P_WORD) == 32'h0);

  a_r5_absent_cpu_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && waddr_i[9:8] == REGION_TGT) |=> (rdata_o & ~T_WORD) == 32'h0);

  a_r6_outside_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && field_region && outside) |=> rdata_o == 32'h0);

  a_r7_type_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && waddr_i == TYPE_WADDR) |=> rdata_o == TYPE_EXP);

  a_r8_ids_constant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (waddr_i == IMPL_WADDR || waddr_i == PERIPH_WADDR)) |=>
      (rdata_o == IMPL_ID || rdata_o == PERIPH_ID));

  a_r9_hold_without_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
endmodule

bind irq_prio_target_regs irq_prio_target_regs_chk #(
  .NUM_IRQS(NUM_IRQS), .NUM_CPUS(NUM_CPUS), .PRIO_BITS(PRIO_BITS),
  .IMPL_ID(IMPL_ID), .PERIPH_ID(PERIPH_ID)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .waddr_i(waddr_i), .rdata_o(rdata_o)
);

// File: tb/irq_prio_target_regs_test.sv
`timescale 1ns/1ps
module irq_prio_target_regs_test;
  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h420, 4'hF, 32'hFFFF_FFFF, 32'h0, 4'd2},
    '{1'b0, 12'h420, 4'hF, 32'h0, 32'hF8F8_F8F8, 4'd2},          // R2 R3
    '{1'b1, 12'h420, 4'hF, 32'hFF7F_BF3F, 32'h0, 4'd3},
    '{1'b0, 12'h420, 4'hF, 32'h0, 32'hF878_B838, 4'd3},          // R3
    '{1'b1, 12'h420, 4'h4, 32'h001F_0000, 32'h0, 4'd4},
    '{1'b0, 12'h420, 4'hF, 32'h0, 32'hF818_B838, 4'd4},          // R4
    '{1'b1, 12'h820, 4'hF, 32'hFFFF_FFFF, 32'h0, 4'd5},
    '{1'b0, 12'h820, 4'hF, 32'h0, 32'h0F0F_0F0F, 4'd5},          // R5
    '{1'b1, 12'h820, 4'hF, 32'h0103_020F, 32'h0, 4'd5},
    '{1'b0, 12'h820, 4'hF, 32'h0, 32'h0103_020F, 4'd5},
    '{1'b0, 12'h420, 4'hF, 32'h0, 32'hF818_B838, 4'd10},         // R10
    '{1'b1, 12'h440, 4'hF, 32'hFFFF_FFFF, 32'h0, 4'd6},
    '{1'b0, 12'h440, 4'hF, 32'h0, 32'h0, 4'd6},                  // R6 beyond
    '{1'b1, 12'h400, 4'hF, 32'hFFFF_FFFF, 32'h0, 4'd6},
    '{1'b0, 12'h400, 4'hF, 32'h0, 32'h0, 4'd6},                  // R6 below 32
    '{1'b1, 12'h43C, 4'hF, 32'hA5A5_5A5A, 32'h0, 4'd2},
    '{1'b0, 12'h43C, 4'hF, 32'h0, 32'hA0A0_5858, 4'd2},          // R2 last word
    '{1'b0, 12'h004, 4'hF, 32'h0, 32'h0000_0061, 4'd7},          // R7
    '{1'b1, 12'h004, 4'hF, 32'hFFFF_FFFF, 32'h0, 4'd8},
    '{1'b0, 12'h004, 4'hF, 32'h0, 32'h0000_0061, 4'd8},          // R8
    '{1'b1, 12'h008, 4'hF, 32'h0, 32'h0, 4'd8},
    '{1'b0, 12'h008, 4'hF, 32'h0, 32'h0001_1A5E, 4'd8},
    '{1'b1, 12'hFE8, 4'hF, 32'hFFFF_FFFF, 32'h0, 4'd8},
    '{1'b0, 12'hFE8, 4'hF, 32'h0, 32'h0000_002B, 4'd8},
    '{1'b1, 12'h820, 4'h2, 32'h0000_FF00, 32'h0, 4'd4},
    '{1'b0, 12'h820, 4'hF, 32'h0, 32'h0103_0F0F, 4'd4}           // R4 target lane 1
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [9:0]  waddr_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  irq_prio_target_regs uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .waddr_i(waddr_i), .be_i(be_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  task automatic check(input int r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual %08h expected %08h", r, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [11:0] a, input logic [3:0] b,
                        input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; waddr_i = a[11:2]; be_i = b; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    rd = rdata_o;
  endtask

  initial begin
    logic [31:0] rd, held;
    #12;
    check(1, rdata_o, 32'h0);                       // R1 during reset
    @(negedge clk_i); rst_ni = 1'b1;
    access(1'b0, 12'h420, 4'hF, 32'h0, rd);
    check(1, rd, 32'h0);                            // R1 priority cleared
    access(1'b0, 12'h820, 4'hF, 32'h0, rd);
    check(1, rd, 32'h0);                            // R1 target cleared

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].we, VECS[i].addr, VECS[i].be, VECS[i].wdata, rd);
      if (!VECS[i].we) check(int'(VECS[i].req), rd, VECS[i].exp);
    end

    // R9: data hold across idle cycles and writes
    access(1'b0, 12'h43C, 4'hF, 32'h0, held);
    check(9, held, 32'hA0A0_5858);
    access(1'b1, 12'h43C, 4'hF, 32'h0, rd);
    check(9, rd, 32'hA0A0_5858);
    repeat (3) @(negedge clk_i);
    check(9, rdata_o, 32'hA0A0_5858);
    access(1'b0, 12'h43C, 4'hF, 32'h0, rd);
    check(9, rd, 32'h0);

    // R10: target write leaves priority intact
    access(1'b1, 12'h820, 4'hF, 32'h0, rd);
    access(1'b0, 12'h420, 4'hF, 32'h0, rd);
    check(10, rd, 32'hF818_B838);

    // R1: reset in the middle of a run
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    check(1, rdata_o, 32'h0);
    rst_ni = 1'b1;
    access(1'b0, 12'h420, 4'hF, 32'h0, rd);
    check(1, rd, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule